// File: doc/BRIEF.md
# Double-Edge 7:1 Flat-Panel Link Serializer

This block turns parallel pixel-lane words into the serial bit streams of an LVDS flat-panel link. Each lane carries seven bits per pixel. The block runs on a fast clock at 3.5 times the pixel rate. Every lane therefore has to produce two bits per fast cycle: one bit for the rising edge and one for the falling edge. A downstream double-edge output cell and a differential buffer, both outside this block, put the pairs on the wire. At the highest pixel rate of 80 MHz, each lane carries 560 Mbit/s.

Seven bits do not split evenly into bit pairs. The block therefore works on two pixels at a time, which take seven fast cycles. One cycle carries the last bit of the first pixel on its rising half and the first bit of the second pixel on its falling half. As a result, successive pixels start alternately on a rising edge and on a falling edge.

A single-cycle load request tells upstream logic when a new pixel word is taken. The lane words are read only on those edges. A fourth, forwarded-clock lane carries a fixed seven-bit pattern that the panel uses to recover pixel framing.

Top module: `lvds_ddr_serializer`

## Requirements
- R1: Every output lane, including the clock lane, carries exactly 7 serial bits per pixel. The serial order within each fast cycle is the rise bit first, then the fall bit.
- R2: The clock lane repeats the group 1100011, written in time order, starting with the first emitted bit after reset. This holds again after every reset.
- R3: Each data lane sends its 7-bit word with bit 6 first and bit 0 last.
- R4: The control lane word is formed as bit 6 = `ctl_de`, bit 5 = `ctl_vsync`, bit 4 = `ctl_hsync`, and bits 3..0 = `ctl_aux[3:0]`.
- R5: `load_req` pulses for one cycle at a time. The gaps between successive pulses alternate 3, 4, 3, 4 cycles and so on, which gives two pixels per seven fast cycles. The first pulse falls in the first cycle after reset is released.
- R6: Lane inputs are sampled only at the clock edge that ends a cycle in which `load_req` is high. Values present in any other cycle have no effect on the serial output.
- R7: While `rst_n` is low, `load_req` and all rise and fall outputs are 0. The outputs stay 0 through the first cycle after release.
- R8: A word taken at the edge that ends cycle t shows its bit 6 during cycle t+2. The bit appears on the rise output for the 1st, 3rd, 5th, … word after reset, and on the fall output for the 2nd, 4th, … word.
- R9: Output bit i of `lane_rise` and `lane_fall` belongs to data lane i, which is fed from `pix_data[7*i+6:7*i]`, for i = 0..2. Output bit 3 is the control lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial clock at 3.5 times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 21 | Three 7-bit data lane words; lane i is in bits 7i+6..7i |
| ctl_de | input | 1 | Data-enable flag for the control lane |
| ctl_vsync | input | 1 | Vertical sync flag for the control lane |
| ctl_hsync | input | 1 | Horizontal sync flag for the control lane |
| ctl_aux | input | 4 | Remaining pixel bits of the control lane |
| load_req | output | 1 | High in the cycle whose ending edge takes the next pixel word |
| lane_rise | output | 4 | Rising-edge bit of data lanes 0..2 and the control lane (bit 3) |
| lane_fall | output | 4 | Falling-edge bit of data lanes 0..2 and the control lane (bit 3) |
| pclk_rise | output | 1 | Rising-edge bit of the forwarded clock lane |
| pclk_fall | output | 1 | Falling-edge bit of the forwarded clock lane |

## Verification
A word taken at the edge ending cycle t starts to appear two cycles later, in cycle t+2. The load request appears in the same cycle as the phase that raises it.

The bench numbers cycles from the release of reset. It samples one nanosecond after each falling edge, and it records output pairs only from cycle 2 onward. It then cuts the recorded streams into 7-bit groups and compares each group with the word that was handed over in a load-request cycle. In every other cycle the bench drives junk on the lane inputs.

The load-request gaps and the first bit after each reset are checked against these exact cycle numbers.

// File: rtl/lvds_ser_pkg.sv
// Shared helpers for the double-edge 7:1 serializer.
// Assumes an odd number of bits per pixel, so two pixels fill BITS fast cycles.
package lvds_ser_pkg;

    // Slot (phase) in which the second pixel of a pair must already be staged
    // minus one: the cycle that requests it.
    function automatic int unsigned second_load_slot(input int unsigned bits);
        return (bits / 2) - 1;
    endfunction

    // Position, in a 2*BITS-bit MSB-first pair vector, of the rise bit for a slot.
    function automatic int unsigned rise_pos(input int unsigned bits, input int unsigned slot);
        return 2 * bits - 1 - 2 * slot;
    endfunction

endpackage

// File: rtl/lvds_phase_seq.sv
// Phase sequencer: cycles a slot counter through 0..BITS-1 and raises the two
// load strobes of a pixel pair. Assumes BITS odd and >= 5. After reset the
// counter sits on the last slot, so the first cycle out of reset loads the
// first pixel, and emission starts one cycle later.
module lvds_phase_seq #(
    parameter int unsigned BITS = 7,
    localparam int unsigned PW = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          emit,
    output logic          load_first,
    output logic          load_second
);
    import lvds_ser_pkg::*;

    localparam logic [PW-1:0] LAST  = PW'(BITS - 1);
    localparam logic [PW-1:0] SLOT2 = PW'(second_load_slot(BITS));

    // Advance the slot counter and arm emission after the first load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= LAST;
            emit  <= 1'b0;
        end else begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
            emit  <= 1'b1;
        end
    end

    // Load strobes: first pixel at the last slot, second mid-pair.
    always_comb begin
        load_first  = rst_n && (phase == LAST);
        load_second = rst_n && emit && (phase == SLOT2);
    end
endmodule

// File: rtl/lvds_pair_stage.sv
// Two-pixel staging buffer for one lane. Holds the first and second pixel
// words of a pair; each half is written only on its own load strobe.
// Assumes the strobes are never high together.
module lvds_pair_stage #(
    parameter int unsigned BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              load_second,
    input  logic [BITS-1:0]   word_in,
    output logic [2*BITS-1:0] pair
);
    logic [BITS-1:0] first_q;
    logic [BITS-1:0] second_q;

    // Capture each half of the pair on its strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (load_first)  first_q  <= word_in;
            if (load_second) second_q <= word_in;
        end
    end

    // Present the pair MSB-first: first pixel bit 6 is the earliest bit.
    always_comb pair = {first_q, second_q};
endmodule

// File: rtl/lvds_slot_pick.sv
// Picks the rise/fall bit pair for the current slot from a 2*BITS-bit
// MSB-first pair vector and registers it. Outputs are 0 in reset and until
// emission is armed.
module lvds_slot_pick #(
    parameter int unsigned BITS = 7,
    localparam int unsigned PW = $clog2(BITS),
    localparam int unsigned IW = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [PW-1:0]     phase,
    input  logic [2*BITS-1:0] pair,
    output logic              bit_rise,
    output logic              bit_fall
);
    import lvds_ser_pkg::*;

    localparam logic [IW-1:0] TOP = IW'(rise_pos(BITS, 0));

    logic [IW-1:0] r_idx;
    logic [IW-1:0] f_idx;

    // Index of the two bits belonging to this slot.
    always_comb begin
        r_idx = TOP - {phase, 1'b0};
        f_idx = r_idx - 1'b1;
    end

    // Register the selected pair for the output cells.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_rise <= 1'b0;
            bit_fall <= 1'b0;
        end else if (emit) begin
            bit_rise <= pair[r_idx];
            bit_fall <= pair[f_idx];
        end
    end
endmodule

// File: rtl/lvds_ddr_serializer.sv
// Double-edge 7:1 serializer top. Stages two pixels per lane, then emits
// them as rise/fall bit pairs over BITS fast cycles, plus a forwarded clock
// lane with a fixed pattern. Assumes the fast clock is 3.5x the pixel rate
// and that upstream presents a word whenever load_req is high.
module lvds_ddr_serializer #(
    parameter int unsigned BITS        = 7,
    parameter int unsigned N_DATA      = 3,
    parameter logic [BITS-1:0] CLK_PAT = 7'b1100011,
    localparam int unsigned N_LANES    = N_DATA + 1,
    localparam int unsigned AUX_W      = BITS - 3
) (
    input  logic                   clk_fast,
    input  logic                   rst_n,
    input  logic [N_DATA*BITS-1:0] pix_data,
    input  logic                   ctl_de,
    input  logic                   ctl_vsync,
    input  logic                   ctl_hsync,
    input  logic [AUX_W-1:0]       ctl_aux,
    output logic                   load_req,
    output logic [N_LANES-1:0]     lane_rise,
    output logic [N_LANES-1:0]     lane_fall,
    output logic                   pclk_rise,
    output logic                   pclk_fall
);
    localparam int unsigned PW = $clog2(BITS);

    logic [PW-1:0]   phase;
    logic            emit;
    logic            load_first;
    logic            load_second;
    logic [BITS-1:0] lane_word [N_LANES];

    lvds_phase_seq #(.BITS(BITS)) u_seq (
        .clk         (clk_fast),
        .rst_n       (rst_n),
        .phase       (phase),
        .emit        (emit),
        .load_first  (load_first),
        .load_second (load_second)
    );

    // One request per consumed pixel word.
    always_comb load_req = load_first | load_second;

    // Map data lanes and pack the control lane fields.
    always_comb begin
        for (int i = 0; i < N_DATA; i++) begin
            lane_word[i] = pix_data[i*BITS +: BITS];
        end
        lane_word[N_DATA] = {ctl_de, ctl_vsync, ctl_hsync, ctl_aux};
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [2*BITS-1:0] pair;

        lvds_pair_stage #(.BITS(BITS)) u_stage (
            .clk         (clk_fast),
            .rst_n       (rst_n),
            .load_first  (load_first),
            .load_second (load_second),
            .word_in     (lane_word[g]),
            .pair        (pair)
        );

        lvds_slot_pick #(.BITS(BITS)) u_pick (
            .clk      (clk_fast),
            .rst_n    (rst_n),
            .emit     (emit),
            .phase    (phase),
            .pair     (pair),
            .bit_rise (lane_rise[g]),
            .bit_fall (lane_fall[g])
        );
    end

    lvds_slot_pick #(.BITS(BITS)) u_clk_pick (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .emit     (emit),
        .phase    (phase),
        .pair     ({CLK_PAT, CLK_PAT}),
        .bit_rise (pclk_rise),
        .bit_fall (pclk_fall)
    );
endmodule

// File: rtl/lvds_ser_checker.sv
// Property checker for lvds_ddr_serializer, attached by bind below.
module lvds_ser_checker #(
    parameter int unsigned BITS   = 7,
    parameter int unsigned N_DATA = 3,
    localparam int unsigned PW    = $clog2(BITS)
) (
    input logic                   clk_fast,
    input logic                   rst_n,
    input logic [N_DATA*BITS-1:0] pix_data,
    input logic                   load_req,
    input logic [N_DATA:0]        lane_rise,
    input logic [N_DATA:0]        lane_fall,
    input logic                   pclk_rise,
    input logic                   pclk_fall,
    input logic [PW-1:0]          phase
);
    localparam logic [PW-1:0] LAST  = PW'(BITS - 1);
    localparam logic [PW-1:0] SLOT2 = PW'(BITS / 2 - 1);

    assert_reset_quiet_R7: assert property (@(posedge clk_fast)
        !rst_n |=> (lane_rise == '0 && lane_fall == '0 && !pclk_rise && !pclk_fall));

    assert_no_req_in_reset_R7: assert property (@(posedge clk_fast)
        !rst_n |-> !load_req);

    assert_req_spacing_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load_req |=> !load_req ##1 !load_req);

    assert_clk_rise_half_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ({pclk_rise, pclk_fall} == 2'b01) |=> ({pclk_rise, pclk_fall} == 2'b11));

    assert_clk_fall_half_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ({pclk_rise, pclk_fall} == 2'b10) |=> ({pclk_rise, pclk_fall} == 2'b00));

    assert_first_on_rise_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (load_req && phase == LAST) |=> ##1 (lane_rise[0] == $past(pix_data[BITS-1], 2)));

    assert_second_on_fall_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (load_req && phase == SLOT2) |=> ##1 (lane_fall[0] == $past(pix_data[BITS-1], 2)));
endmodule

bind lvds_ddr_serializer lvds_ser_checker #(.BITS(BITS), .N_DATA(N_DATA)) u_chk (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .pix_data  (pix_data),
    .load_req  (load_req),
    .lane_rise (lane_rise),
    .lane_fall (lane_fall),
    .pclk_rise (pclk_rise),
    .pclk_fall (pclk_fall),
    .phase     (phase)
);

// File: tb/tb_lvds_ddr_serializer.sv
// Bench: walks a vector table through the serializer, rebuilds each lane's
// serial stream from the rise/fall pairs and compares 7-bit groups.
module tb_lvds_ddr_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] pix_data = '0;
    logic        ctl_de = 1'b0, ctl_vsync = 1'b0, ctl_hsync = 1'b0;
    logic [3:0]  ctl_aux = '0;
    logic        load_req;
    logic [3:0]  lane_rise, lane_fall;
    logic        pclk_rise, pclk_fall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Vector layout: {de, vsync, hsync, aux[3:0], lane2, lane1, lane0}
    localparam int NV = 16;
    localparam logic [27:0] VEC [NV] = '{
        28'h0000000, 28'hFFFFFFF, 28'hAAAAAAA, 28'h5555555,
        28'h8000000, 28'h4000000, 28'h2000000, 28'h0000001,
        28'h1234567, 28'h89ABCDE, 28'h0F0F0F0, 28'hE38E38E,
        28'h7FFFFFF, 28'h1000040, 28'h0204081, 28'hC6D2B19
    };
    localparam logic [6:0] CLK_GRP = 7'b1100011;

    logic stream [5][512];

    lvds_ddr_serializer dut (
        .clk_fast (clk), .rst_n (rst_n), .pix_data (pix_data),
        .ctl_de (ctl_de), .ctl_vsync (ctl_vsync), .ctl_hsync (ctl_hsync),
        .ctl_aux (ctl_aux), .load_req (load_req),
        .lane_rise (lane_rise), .lane_fall (lane_fall),
        .pclk_rise (pclk_rise), .pclk_fall (pclk_fall)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive_vec(input logic [27:0] v);
        {ctl_de, ctl_vsync, ctl_hsync, ctl_aux, pix_data} = v;
    endtask

    // Run from just after reset release: nvec words from the table starting at
    // first_vec, junk in every non-request cycle, then compare the groups.
    task automatic run_burst(input int first_vec, input int nvec);
        int ncyc = 2 + (nvec * 7 + 1) / 2 + 1;
        int nbits = 0;
        int nload = 0;
        int last_load = 0;
        for (int c = 0; c < ncyc; c++) begin
            #1;
            if (c < 2) begin
                check(lane_rise == 0 && lane_fall == 0 && !pclk_rise && !pclk_fall,
                      "R7 outputs quiet after release", {lane_rise, lane_fall}, 0);
            end else begin
                for (int l = 0; l < 4; l++) begin
                    stream[l][nbits]   = lane_rise[l];
                    stream[l][nbits+1] = lane_fall[l];
                end
                stream[4][nbits]   = pclk_rise;
                stream[4][nbits+1] = pclk_fall;
                nbits += 2;
            end
            if (c == 0) check(load_req == 1'b1, "R5 first request in cycle 0", load_req, 1);
            if (load_req) begin
                if (nload > 0)
                    check(c - last_load == ((nload % 2 == 1) ? 3 : 4),
                          "R5 request gap", c - last_load, (nload % 2 == 1) ? 3 : 4);
                last_load = c;
                nload++;
                drive_vec((nload - 1 < nvec) ? VEC[(first_vec + nload - 1) % NV] : 28'h0);
            end else begin
                drive_vec(28'hFFFFFFF ^ 28'(c * 32'h0135_79BD));
            end
            @(negedge clk);
        end
        // R8: first bit of word 0 on rise of cycle 2, word 1 on fall of cycle 5
        check(stream[0][0] == VEC[first_vec % NV][6], "R8 word0 bit6 on rise cycle2",
              stream[0][0], VEC[first_vec % NV][6]);
        check(stream[0][7] == VEC[(first_vec + 1) % NV][6], "R8 word1 bit6 on fall cycle5",
              stream[0][7], VEC[(first_vec + 1) % NV][6]);
        check(nbits >= nvec * 7, "R1 stream length", nbits, nvec * 7);
        for (int g = 0; g < nvec; g++) begin
            logic [27:0] v = VEC[(first_vec + g) % NV];
            for (int l = 0; l < 5; l++) begin
                logic [6:0] got, exp;
                for (int j = 0; j < 7; j++) got[6-j] = stream[l][g*7+j];
                exp = (l == 4) ? CLK_GRP : v[l*7 +: 7];
                case (l)
                    4:       check(got == exp, "R1 R2 clock lane group", got, exp);
                    3:       check(got == exp, "R4 control lane de/vs/hs/aux", got, exp);
                    default: check(got == exp, "R3 R6 R9 data lane group", got, exp);
                endcase
            end
        end
    endtask

    initial begin
        drive_vec(28'h5A5A5A5);
        repeat (4) @(negedge clk);
        #1;
        check(load_req == 0 && lane_rise == 0 && lane_fall == 0 && !pclk_rise && !pclk_fall,
              "R7 reset state", {load_req, lane_rise, lane_fall}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_vec(VEC[0]);
        run_burst(0, NV);

        // Directed: reset mid-stream, then restart the pattern.
        rst_n = 1'b0;
        drive_vec(28'h3C3C3C3);
        repeat (3) @(negedge clk);
        #1;
        check(load_req == 0 && lane_rise == 0 && lane_fall == 0 && !pclk_rise && !pclk_fall,
              "R7 mid-run reset quiet", {load_req, lane_rise, lane_fall}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_vec(VEC[9]);
        run_burst(9, 5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule